// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside a BCD real-time clock and decides when the hour counter must be moved for daylight saving. It watches the clock's month, date, weekday, hour, minute and second, plus the clock's 12/24-hour mode bit. It compares them with two rule sets: a spring-forward rule and a fall-back rule. When a rule point is reached, the block emits a single-cycle pulse. The clock's hour counter uses that pulse to add one hour, or to subtract one hour.

Each rule holds a month, a calendar date, a weekday, a day-select bit, an hour byte and its own hour-mode bit. The day-select bit chooses whether the weekday or the calendar date picks the switchover day. A rule fires only if all of the following hold:
- the master enable is set;
- the rule's hour-mode bit equals the clock's hour-mode bit;
- minutes and seconds are both 00.

The fall-back rule also has a one-shot guard. When the clock is set back, the same 02:00:00 occurs a second time on that date, and the guard keeps that second occurrence from firing again.

Top module: `dst_shift`

## Requirements
- R1: While reset is high, and in the cycle after reset, both `hour_adv` and `hour_ret` are 0.
- R2: `hour_adv` is high for exactly one cycle, in the cycle after the first cycle in which all of the following hold: `dst_en`=1, month equals `fwd_month`, the day matches, the hour byte equals `fwd_hour`, minute=00h, second=00h and `now_mil` equals `fwd_mil`. It stays low while that condition persists. The same applies to `hour_ret` with the `rev_*` fields.
- R3: When a rule's day-select bit is 1, the day matches on weekday equality (0 to 6, 0 = Sunday), and the calendar date is ignored.
- R4: When a rule's day-select bit is 0, the day matches on calendar date equality (BCD), and the weekday is ignored.
- R5: No pulse is produced while the clock's hour-mode bit differs from the rule's hour-mode bit.
- R6: With `dst_en`=0, neither output pulses.
- R7: No pulse is produced while the minute or the second is not 00h.
- R8: After `hour_ret` fires, a new match of the fall-back rule does not fire while the date is unchanged. Once the date input changes, the fall-back rule can fire again. The spring-forward rule has no such guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dst_en | input | 1 | Master enable for both corrections |
| now_month | input | 8 | Clock month, BCD 01h-12h |
| now_date | input | 8 | Clock date, BCD |
| now_wday | input | 3 | Clock weekday, 0-6 |
| now_hour | input | 8 | Clock hour byte, compared whole (includes PM bit in 12-hour mode) |
| now_mil | input | 1 | Clock hour mode, 1 = 24-hour |
| now_min | input | 8 | Clock minute, BCD |
| now_sec | input | 8 | Clock second, BCD |
| fwd_month | input | 8 | Start rule month |
| fwd_date | input | 8 | Start rule date |
| fwd_wday | input | 3 | Start rule weekday |
| fwd_by_wday | input | 1 | Start rule day-select: 1 = weekday, 0 = date |
| fwd_hour | input | 8 | Start rule hour byte |
| fwd_mil | input | 1 | Start rule hour mode |
| rev_month | input | 8 | End rule month |
| rev_date | input | 8 | End rule date |
| rev_wday | input | 3 | End rule weekday |
| rev_by_wday | input | 1 | End rule day-select: 1 = weekday, 0 = date |
| rev_hour | input | 8 | End rule hour byte |
| rev_mil | input | 1 | End rule hour mode |
| hour_adv | output | 1 | One-cycle pulse: add one hour |
| hour_ret | output | 1 | One-cycle pulse: subtract one hour |

## Verification
Both pulses come from a single register stage. A time presented before a rising edge therefore shows up on `hour_adv` or `hour_ret` right after that same edge, and it clears one edge later. The bench changes the clock inputs on the falling edge and waits for one rising edge. It then compares the outputs at the next falling edge against a model. That model keeps its own record of the previous match levels, the fall-back guard and the last date seen. Directed steps cover each day-select mode, a mode mismatch, enable off, nonzero minute and second, and the repeated 02:00:00. Seeded random times clustered around the rule points then exercise the same rules.

// File: rtl/dst_pkg.sv
package dst_pkg;
  localparam int DST_BCD_W  = 8;
  localparam int DST_WDAY_W = 3;
  localparam int DST_NRULES = 2;

  typedef enum logic [0:0] {
    RULE_FWD = 1'b0,
    RULE_REV = 1'b1
  } dst_rule_e;
endpackage

// File: rtl/dst_rule_match.sv
module dst_rule_match #(
  parameter int BCD_W  = 8,
  parameter int WDAY_W = 3
) (
  input  logic              en,
  input  logic [BCD_W-1:0]  now_month,
  input  logic [BCD_W-1:0]  now_date,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic [BCD_W-1:0]  now_hour,
  input  logic              now_mil,
  input  logic [BCD_W-1:0]  now_min,
  input  logic [BCD_W-1:0]  now_sec,
  input  logic [BCD_W-1:0]  r_month,
  input  logic [BCD_W-1:0]  r_date,
  input  logic [WDAY_W-1:0] r_wday,
  input  logic              r_by_wday,
  input  logic [BCD_W-1:0]  r_hour,
  input  logic              r_mil,
  output logic              hit
);
  logic day_ok;
  logic top_of_hour;
  logic fmt_ok;

  always_comb begin
    day_ok      = r_by_wday ? (now_wday == r_wday) : (now_date == r_date);
    top_of_hour = (now_min == '0) && (now_sec == '0);
    fmt_ok      = (now_mil == r_mil);
    hit         = en && fmt_ok && top_of_hour && day_ok &&
                  (now_month == r_month) && (now_hour == r_hour);
  end
endmodule

// File: rtl/dst_fire.sv
module dst_fire #(
  parameter int BCD_W    = 8,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [BCD_W-1:0] now_date,
  output logic             pulse
);
  logic hit_q;
  logic rise;
  logic blocked;

  assign rise = hit && !hit_q;

  generate
    if (ONE_SHOT) begin : g_guard
      logic             done_q;
      logic [BCD_W-1:0] date_q;
      logic             new_day;

      assign new_day = (now_date != date_q);
      assign blocked = done_q && !new_day;

      always_ff @(posedge clk) begin
        if (rst) begin
          done_q <= 1'b0;
          date_q <= '0;
        end else begin
          date_q <= now_date;
          if (rise && !blocked) done_q <= 1'b1;
          else if (new_day)     done_q <= 1'b0;
        end
      end
    end else begin : g_free
      assign blocked = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      pulse <= 1'b0;
    end else begin
      hit_q <= hit;
      pulse <= rise && !blocked;
    end
  end
endmodule

// File: rtl/dst_shift.sv
module dst_shift
  import dst_pkg::*;
#(
  parameter int BCD_W  = DST_BCD_W,
  parameter int WDAY_W = DST_WDAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dst_en,
  input  logic [BCD_W-1:0]  now_month,
  input  logic [BCD_W-1:0]  now_date,
  input  logic [WDAY_W-1:0] now_wday,
  input  logic [BCD_W-1:0]  now_hour,
  input  logic              now_mil,
  input  logic [BCD_W-1:0]  now_min,
  input  logic [BCD_W-1:0]  now_sec,
  input  logic [BCD_W-1:0]  fwd_month,
  input  logic [BCD_W-1:0]  fwd_date,
  input  logic [WDAY_W-1:0] fwd_wday,
  input  logic              fwd_by_wday,
  input  logic [BCD_W-1:0]  fwd_hour,
  input  logic              fwd_mil,
  input  logic [BCD_W-1:0]  rev_month,
  input  logic [BCD_W-1:0]  rev_date,
  input  logic [WDAY_W-1:0] rev_wday,
  input  logic              rev_by_wday,
  input  logic [BCD_W-1:0]  rev_hour,
  input  logic              rev_mil,
  output logic              hour_adv,
  output logic              hour_ret
);
  localparam int NR = DST_NRULES;

  logic [BCD_W-1:0]  rl_month [NR];
  logic [BCD_W-1:0]  rl_date  [NR];
  logic [WDAY_W-1:0] rl_wday  [NR];
  logic              rl_bywd  [NR];
  logic [BCD_W-1:0]  rl_hour  [NR];
  logic              rl_mil   [NR];
  logic [NR-1:0]     rl_hit;
  logic [NR-1:0]     rl_pulse;

  always_comb begin
    rl_month[RULE_FWD] = fwd_month;   rl_month[RULE_REV] = rev_month;
    rl_date[RULE_FWD]  = fwd_date;    rl_date[RULE_REV]  = rev_date;
    rl_wday[RULE_FWD]  = fwd_wday;    rl_wday[RULE_REV]  = rev_wday;
    rl_bywd[RULE_FWD]  = fwd_by_wday; rl_bywd[RULE_REV]  = rev_by_wday;
    rl_hour[RULE_FWD]  = fwd_hour;    rl_hour[RULE_REV]  = rev_hour;
    rl_mil[RULE_FWD]   = fwd_mil;     rl_mil[RULE_REV]   = rev_mil;
  end

  generate
    for (genvar g = 0; g < NR; g++) begin : g_rule
      dst_rule_match #(.BCD_W(BCD_W), .WDAY_W(WDAY_W)) u_match (
        .en        (dst_en),
        .now_month (now_month),
        .now_date  (now_date),
        .now_wday  (now_wday),
        .now_hour  (now_hour),
        .now_mil   (now_mil),
        .now_min   (now_min),
        .now_sec   (now_sec),
        .r_month   (rl_month[g]),
        .r_date    (rl_date[g]),
        .r_wday    (rl_wday[g]),
        .r_by_wday (rl_bywd[g]),
        .r_hour    (rl_hour[g]),
        .r_mil     (rl_mil[g]),
        .hit       (rl_hit[g])
      );

      dst_fire #(.BCD_W(BCD_W), .ONE_SHOT(g == int'(RULE_REV))) u_fire (
        .clk      (clk),
        .rst      (rst),
        .hit      (rl_hit[g]),
        .now_date (now_date),
        .pulse    (rl_pulse[g])
      );
    end
  endgenerate

  assign hour_adv = rl_pulse[RULE_FWD];
  assign hour_ret = rl_pulse[RULE_REV];
endmodule

// File: rtl/dst_shift_chk.sv
module dst_shift_chk #(
  parameter int BCD_W  = 8,
  parameter int WDAY_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              dst_en,
  input logic [BCD_W-1:0]  now_date,
  input logic [WDAY_W-1:0] now_wday,
  input logic              now_mil,
  input logic [BCD_W-1:0]  now_min,
  input logic [BCD_W-1:0]  now_sec,
  input logic [BCD_W-1:0]  fwd_date,
  input logic [WDAY_W-1:0] fwd_wday,
  input logic              fwd_by_wday,
  input logic              fwd_mil,
  input logic              rev_mil,
  input logic              hour_adv,
  input logic              hour_ret
);
  // R1
  post_reset_quiet_chk: assert property (@(posedge clk) $fell(rst) |-> !hour_adv && !hour_ret);

  // R2
  adv_single_chk: assert property (@(posedge clk) disable iff (rst) hour_adv |=> !hour_adv);

  // R2
  ret_single_chk: assert property (@(posedge clk) disable iff (rst) hour_ret |=> !hour_ret);

  // R3
  adv_wday_chk: assert property (@(posedge clk) disable iff (rst)
    hour_adv && $past(fwd_by_wday) |-> $past(now_wday == fwd_wday));

  // R4
  adv_date_chk: assert property (@(posedge clk) disable iff (rst)
    hour_adv && !$past(fwd_by_wday) |-> $past(now_date == fwd_date));

  // R5
  fmt_match_chk: assert property (@(posedge clk) disable iff (rst)
    (hour_adv |-> $past(now_mil == fwd_mil)) and (hour_ret |-> $past(now_mil == rev_mil)));

  // R6
  enable_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (hour_adv || hour_ret) |-> $past(dst_en));

  // R7
  top_of_hour_chk: assert property (@(posedge clk) disable iff (rst)
    (hour_adv || hour_ret) |-> ($past(now_min) == '0 && $past(now_sec) == '0));
endmodule

bind dst_shift dst_shift_chk #(.BCD_W(BCD_W), .WDAY_W(WDAY_W)) u_chk (.*);

// File: tb/dst_shift_bench.sv
module dst_shift_bench;
  localparam int BW = 8;
  localparam int WW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dst_en = 1'b1;
  logic [BW-1:0] now_month = 8'h01, now_date = 8'h01, now_hour = 8'h00, now_min = 8'h00, now_sec = 8'h00;
  logic [WW-1:0] now_wday = 3'd0;
  logic now_mil = 1'b1;
  logic [BW-1:0] fwd_month = 8'h03, fwd_date = 8'h08, fwd_hour = 8'h02;
  logic [WW-1:0] fwd_wday = 3'd0;
  logic fwd_by_wday = 1'b1, fwd_mil = 1'b1;
  logic [BW-1:0] rev_month = 8'h10, rev_date = 8'h01, rev_hour = 8'h02;
  logic [WW-1:0] rev_wday = 3'd0;
  logic rev_by_wday = 1'b1, rev_mil = 1'b1;
  logic hour_adv, hour_ret;

  int total = 0;
  int bad = 0;
  bit m_pf = 0, m_pr = 0, m_done = 0;
  logic [BW-1:0] m_last_date = '0;

  always #10 clk = ~clk;

  dst_shift u_dst_shift (.*);

  function automatic bit rule_hit(input bit rev);
    logic [BW-1:0] mo, dt, hr;
    logic [WW-1:0] wd;
    bit bywd, ml, day_ok;
    mo = rev ? rev_month : fwd_month;   dt = rev ? rev_date : fwd_date;
    hr = rev ? rev_hour : fwd_hour;     wd = rev ? rev_wday : fwd_wday;
    bywd = rev ? rev_by_wday : fwd_by_wday;
    ml = rev ? rev_mil : fwd_mil;
    day_ok = bywd ? (now_wday == wd) : (now_date == dt);
    return dst_en && (now_mil == ml) && day_ok && now_month == mo &&
           now_hour == hr && now_min == 8'h00 && now_sec == 8'h00;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // caller has set inputs after a falling edge
  task automatic step(input string tag);
    bit fh, rh, ef, er, newday;
    @(posedge clk);
    fh = rule_hit(1'b0);
    rh = rule_hit(1'b1);
    newday = (now_date != m_last_date);
    ef = fh && !m_pf;
    er = rh && !m_pr && !(m_done && !newday);
    if (er) m_done = 1'b1;
    else if (newday) m_done = 1'b0;
    m_last_date = now_date;
    m_pf = fh;
    m_pr = rh;
    @(negedge clk);
    check(tag, hour_adv, ef, "hour_adv");
    check(tag, hour_ret, er, "hour_ret");
  endtask

  task automatic set_t(input logic [7:0] mo, input logic [7:0] dt, input logic [2:0] wd,
                       input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
    now_month = mo; now_date = dt; now_wday = wd;
    now_hour = hr; now_min = mi; now_sec = se;
  endtask

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    check("R1", hour_adv, 1'b0, "hour_adv in reset");
    check("R1", hour_ret, 1'b0, "hour_ret in reset");
    rst = 1'b0;
    // R1 / R2: spring forward by weekday (Sunday in March at 02:00:00)
    set_t(8'h03, 8'h08, 3'd0, 8'h01, 8'h59, 8'h59); step("R1");
    set_t(8'h03, 8'h08, 3'd0, 8'h02, 8'h00, 8'h00); step("R2");
    step("R2");  // held: no second pulse
    set_t(8'h03, 8'h08, 3'd0, 8'h03, 8'h00, 8'h00); step("R2");
    // R3: fall back by weekday, date field ignored
    set_t(8'h10, 8'h15, 3'd0, 8'h01, 8'h59, 8'h59); step("R3");
    set_t(8'h10, 8'h15, 3'd0, 8'h02, 8'h00, 8'h00); step("R3");
    // R8: repeated 02:00:00 the same date stays quiet
    set_t(8'h10, 8'h15, 3'd0, 8'h01, 8'h00, 8'h00); step("R8");
    set_t(8'h10, 8'h15, 3'd0, 8'h02, 8'h00, 8'h00); step("R8");
    set_t(8'h10, 8'h16, 3'd1, 8'h02, 8'h00, 8'h00); step("R3");
    set_t(8'h10, 8'h22, 3'd0, 8'h02, 8'h00, 8'h00); step("R8");
    // R4: date priority, weekday ignored
    rev_by_wday = 1'b0;
    set_t(8'h10, 8'h01, 3'd3, 8'h01, 8'h00, 8'h00); step("R4");
    set_t(8'h10, 8'h01, 3'd3, 8'h02, 8'h00, 8'h00); step("R4");
    set_t(8'h10, 8'h02, 3'd0, 8'h02, 8'h00, 8'h00); step("R4");
    rev_by_wday = 1'b1;
    // R5: hour-mode mismatch
    set_t(8'h03, 8'h08, 3'd0, 8'h01, 8'h00, 8'h00); step("R5");
    now_mil = 1'b0;
    set_t(8'h03, 8'h08, 3'd0, 8'h02, 8'h00, 8'h00); step("R5");
    now_mil = 1'b1;
    set_t(8'h03, 8'h09, 3'd1, 8'h01, 8'h00, 8'h00); step("R5");
    // R6: disabled
    dst_en = 1'b0;
    set_t(8'h03, 8'h15, 3'd0, 8'h02, 8'h00, 8'h00); step("R6");
    set_t(8'h10, 8'h15, 3'd0, 8'h02, 8'h00, 8'h00); step("R6");
    dst_en = 1'b1;
    // R7: minute or second nonzero
    set_t(8'h03, 8'h22, 3'd0, 8'h02, 8'h01, 8'h00); step("R7");
    set_t(8'h03, 8'h22, 3'd0, 8'h02, 8'h00, 8'h30); step("R7");
    set_t(8'h03, 8'h22, 3'd0, 8'h02, 8'h00, 8'h00); step("R7");
    // random mix around the rule points
    for (int i = 0; i < 2000; i++) begin
      int pick;
      if (i % 64 == 0) begin
        fwd_by_wday = 1'($urandom);
        rev_by_wday = 1'($urandom);
        fwd_date = to_bcd(1 + $urandom % 3);
        rev_date = to_bcd(1 + $urandom % 3);
      end
      pick = $urandom % 4;
      now_month = (pick == 0) ? 8'h03 : (pick == 1) ? 8'h10 : to_bcd(1 + $urandom % 12);
      if ($urandom % 4 == 0) now_date = to_bcd(1 + $urandom % 3);
      now_wday = 3'($urandom % 7);
      now_hour = to_bcd(1 + $urandom % 3);
      now_min = ($urandom % 4 == 0) ? to_bcd($urandom % 60) : 8'h00;
      now_sec = ($urandom % 4 == 0) ? to_bcd($urandom % 60) : 8'h00;
      now_mil = ($urandom % 8 != 0);
      dst_en = ($urandom % 8 != 0);
      step("R2 R8 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule